// File: doc/BRIEF.md
# Dual-Line Serial Frame Monitor

This block listens, without driving anything, to the two wires of an asynchronous serial link: the receive line and the transmit line. Each wire has its own synchronizer, falling-edge detector and frame decoder, so traffic in both directions is decoded at the same time. A decoder starts a frame when the idle-high wire falls. It then samples each bit at the centre of its bit cell. The bits it checks are the start bit, 5 to 9 data bits in either bit order, an optional parity bit and one stop bit.

Each field decoded becomes a tagged event record of the form {direction, kind, payload}. The two channels feed one valid/ready output. An event is offered while `ev_valid` is high and is consumed on a rising clock edge where `ev_ready` is also high. An offered event does not change until it is consumed.

If both channels produce an event in the same cycle, the receive event goes to the output and the transmit event waits in a one-entry holding slot. Back-pressure is absorbed only by the output register and that one slot. A sink that stalls long enough for both to stay full loses any further events. Events of one channel are at least one bit period apart, so a sink that stalls for fewer than half a bit period never loses an event.

Bit timing (clocks per bit), data width, bit order, parity mode and the per-line enables are plain configuration inputs. They must be held steady while a frame is in flight.

Top module: `uart_frame_monitor`

## Requirements
- R1: After reset `ev_valid` is low and stays low until a frame has been decoded.
- R2: A high-to-low transition on an idle enabled line starts a frame. The start bit is sampled half a bit period later. A start bit read as 0 produces event kind 0 with payload 0, and `ev_valid` for it rises on the (cfg_clks_per_bit/2 + 3)-th rising clock edge after the line falls, with the output otherwise idle.
- R3: A start bit read as 1 produces kind 5 with payload 1. Decoding does not abort: the data, parity and stop events of that frame still follow.
- R4: With `cfg_msb_first` = 0, the first data bit on the wire is bit 0 of the value. The bit count comes from `cfg_data_bits` (5 to 9). After the last data bit a kind 1 event carries the value, zero-extended to 9 bits.
- R5: With `cfg_msb_first` = 1, the first data bit on the wire is the most significant bit of the N-bit value. The event is the same as in R4.
- R6: Parity codes 1 (odd) and 2 (even) require the number of ones over the data bits and the parity bit to be odd or even. A match gives kind 2 with the received parity bit as payload. A mismatch gives kind 3 with payload[1] = expected parity bit and payload[0] = received parity bit.
- R7: Parity code 3 requires a parity bit of 0 and code 4 requires a parity bit of 1. These codes use the same event kinds and payloads as R6.
- R8: With parity code 0 no parity event is produced, and the stop bit is taken from bit position N+1.
- R9: A stop bit read as 1 gives kind 4 with payload 1. A stop bit read as 0 gives kind 6 with payload 0. In both cases the channel then waits for a new falling edge.
- R10: Events from the receive line carry `ev_dir` = 0 and events from the transmit line carry `ev_dir` = 1. The two lines are decoded independently and at the same time.
- R11: A line whose enable is low produces no events whatever it carries. At least one enable is high.
- R12: While `ev_valid` is high and `ev_ready` is low, the offered event stays unchanged. When both channels produce an event in the same cycle, the receive event is offered first and the transmit event follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Receive-direction serial wire (asynchronous) |
| tx_line | input | 1 | Transmit-direction serial wire (asynchronous) |
| rx_en | input | 1 | Enable decoding of the receive wire |
| tx_en | input | 1 | Enable decoding of the transmit wire |
| cfg_clks_per_bit | input | CPB_W | Bit period in clock cycles (at least 4) |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 always 0, 4 always 1 |
| ev_valid | output | 1 | An event is offered |
| ev_ready | input | 1 | Sink accepts the offered event |
| ev_dir | output | 1 | 0 receive, 1 transmit |
| ev_kind | output | 3 | 0 start, 1 data, 2 parity ok, 3 parity error, 4 stop, 5 bad start, 6 bad stop |
| ev_payload | output | 9 | Field value (see requirements) |

## Verification
The assertions assume the configuration is legal and steady during a frame: a bit period of at least 4 clocks, a data width of 5 to 9, and at least one line enabled. The bench changes the configuration only between frames, while both wires are idle, and always uses a period of 8 clocks. Stimulus also keeps within the stated back-pressure rule. The sink stalls only for a few cycles, right after simultaneous start events, while the next field of either channel is still most of a bit period away. Under these conditions no event is dropped, and the bench can expect every field in order.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

  localparam int MON_DW = 9;

  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_DATA      = 3'd1,
    EV_PAR_OK    = 3'd2,
    EV_PAR_ERR   = 3'd3,
    EV_STOP      = 3'd4,
    EV_BAD_START = 3'd5,
    EV_BAD_STOP  = 3'd6
  } ev_kind_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef struct packed {
    logic              dir;
    ev_kind_e          kind;
    logic [MON_DW-1:0] payload;
  } mon_event_t;

endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] sr;
  logic              prev;

  // Reset to the idle (high) level so no false edge appears after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
  assign fall  = prev & ~sr[STAGES-1];

endmodule

// File: rtl/uart_frame_decoder.sv
module uart_frame_decoder
  import uart_mon_pkg::*;
#(
  parameter int CPB_W   = 16,
  parameter bit DIR_TAG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             line,
  input  logic             line_fall,
  input  logic [CPB_W-1:0] cfg_cpb,
  input  logic [3:0]       cfg_nbits,
  input  logic             cfg_msb_first,
  input  par_mode_e        cfg_parity,
  output logic             ev_valid,
  output mon_event_t       ev
);

  localparam int DW = MON_DW;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } dec_state_e;

  dec_state_e       state;
  logic [CPB_W-1:0] cnt;
  logic [CPB_W-1:0] half_m1;
  logic [3:0]       bit_idx;
  logic [DW-1:0]    shreg;
  logic [DW-1:0]    shreg_next;
  logic             tick;
  logic             last_bit;
  logic             exp_par;

  assign half_m1  = (cfg_cpb >> 1) - CPB_W'(1);
  assign tick     = (state != S_IDLE) && (cnt == '0);
  assign last_bit = (bit_idx == cfg_nbits - 4'd1);

  // New bit enters at the top of the N-bit field (shift right) or at bit 0.
  always_comb begin
    if (cfg_msb_first)
      shreg_next = {shreg[DW-2:0], line};
    else
      shreg_next = (shreg >> 1) | ({{(DW-1){1'b0}}, line} << (cfg_nbits - 4'd1));
  end

  always_comb begin
    unique case (cfg_parity)
      PAR_ODD:   exp_par = ~^shreg;
      PAR_EVEN:  exp_par = ^shreg;
      PAR_SPACE: exp_par = 1'b0;
      default:   exp_par = 1'b1;
    endcase
  end

  always_comb begin
    ev_valid   = 1'b0;
    ev.dir     = DIR_TAG;
    ev.kind    = EV_START;
    ev.payload = '0;
    if (enable && tick) begin
      unique case (state)
        S_START: begin
          ev_valid   = 1'b1;
          ev.kind    = line ? EV_BAD_START : EV_START;
          ev.payload = {{(DW-1){1'b0}}, line};
        end
        S_DATA: begin
          ev_valid   = last_bit;
          ev.kind    = EV_DATA;
          ev.payload = shreg_next;
        end
        S_PAR: begin
          ev_valid = 1'b1;
          if (line == exp_par) begin
            ev.kind    = EV_PAR_OK;
            ev.payload = {{(DW-1){1'b0}}, line};
          end else begin
            ev.kind    = EV_PAR_ERR;
            ev.payload = {{(DW-2){1'b0}}, exp_par, line};
          end
        end
        S_STOP: begin
          ev_valid   = 1'b1;
          ev.kind    = line ? EV_STOP : EV_BAD_STOP;
          ev.payload = {{(DW-1){1'b0}}, line};
        end
        default: ev_valid = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (!enable) begin
      state <= S_IDLE;
    end else if (state == S_IDLE) begin
      if (line_fall) begin
        state <= S_START;
        cnt   <= half_m1;
      end
    end else if (tick) begin
      cnt <= cfg_cpb - CPB_W'(1);
      unique case (state)
        S_START: begin
          shreg   <= '0;
          bit_idx <= '0;
          state   <= S_DATA;
        end
        S_DATA: begin
          shreg <= shreg_next;
          if (last_bit)
            state <= (cfg_parity == PAR_NONE) ? S_STOP : S_PAR;
          else
            bit_idx <= bit_idx + 4'd1;
        end
        S_PAR:   state <= S_STOP;
        default: state <= S_IDLE;
      endcase
    end else begin
      cnt <= cnt - CPB_W'(1);
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !ev_valid); // R11

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev.kind == EV_STOP || ev.kind == EV_BAD_STOP) |=> state == S_IDLE); // R9

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |-> cfg_nbits >= 4'd5 && cfg_nbits <= 4'd9 && cfg_cpb >= CPB_W'(4)); // R4

  AST_NO_PARITY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && cfg_parity == PAR_NONE |-> ev.kind != EV_PAR_OK && ev.kind != EV_PAR_ERR); // R8

  AST_BAD_START_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev.kind == EV_BAD_START |=> state == S_DATA); // R3

endmodule

// File: rtl/uart_event_merge.sv
module uart_event_merge
  import uart_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  mon_event_t rx_ev,
  input  logic       tx_valid,
  input  mon_event_t tx_ev,
  output logic       out_valid,
  input  logic       out_ready,
  output mon_event_t out_ev
);

  logic       free;
  logic       hold_v;
  mon_event_t hold_ev;

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ev    <= '0;
      hold_v    <= 1'b0;
      hold_ev   <= '0;
    end else if (free) begin
      if (rx_valid) begin
        out_valid <= 1'b1;
        out_ev    <= rx_ev;
        if (tx_valid && !hold_v) begin
          hold_v  <= 1'b1;
          hold_ev <= tx_ev;
        end
      end else if (hold_v) begin
        out_valid <= 1'b1;
        out_ev    <= hold_ev;
        if (tx_valid)
          hold_ev <= tx_ev;
        else
          hold_v <= 1'b0;
      end else if (tx_valid) begin
        out_valid <= 1'b1;
        out_ev    <= tx_ev;
      end else begin
        out_valid <= 1'b0;
      end
    end else if (tx_valid && !hold_v) begin
      hold_v  <= 1'b1;
      hold_ev <= tx_ev;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ev)); // R12

  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    free && rx_valid |=> out_valid && out_ev.dir == rx_ev.dir && !out_ev.dir); // R12

  AST_TX_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ev.dir); // R10

endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor
  import uart_mon_pkg::*;
#(
  parameter int CPB_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tx_line,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [CPB_W-1:0]  cfg_clks_per_bit,
  input  logic [3:0]        cfg_data_bits,
  input  logic              cfg_msb_first,
  input  logic [2:0]        cfg_parity,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic              ev_dir,
  output logic [2:0]        ev_kind,
  output logic [MON_DW-1:0] ev_payload
);

  localparam int NCH = 2;

  logic [NCH-1:0] raw_line;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] ch_level;
  logic [NCH-1:0] ch_fall;
  logic [NCH-1:0] ch_valid;
  mon_event_t     ch_ev [NCH];
  mon_event_t     out_ev;
  par_mode_e      par_mode;

  assign raw_line = {tx_line, rx_line};
  assign ch_en    = {tx_en, rx_en};
  assign par_mode = par_mode_e'(cfg_parity);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_line[c]),
      .level (ch_level[c]),
      .fall  (ch_fall[c])
    );

    uart_frame_decoder #(.CPB_W(CPB_W), .DIR_TAG(c == 1)) u_dec (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (ch_en[c]),
      .line          (ch_level[c]),
      .line_fall     (ch_fall[c]),
      .cfg_cpb       (cfg_clks_per_bit),
      .cfg_nbits     (cfg_data_bits),
      .cfg_msb_first (cfg_msb_first),
      .cfg_parity    (par_mode),
      .ev_valid      (ch_valid[c]),
      .ev            (ch_ev[c])
    );
  end

  uart_event_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (ch_valid[0]),
    .rx_ev     (ch_ev[0]),
    .tx_valid  (ch_valid[1]),
    .tx_ev     (ch_ev[1]),
    .out_valid (ev_valid),
    .out_ready (ev_ready),
    .out_ev    (out_ev)
  );

  assign ev_dir     = out_ev.dir;
  assign ev_kind    = out_ev.kind;
  assign ev_payload = out_ev.payload;

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en || tx_en); // R11

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(ch_valid != '0)); // R1

endmodule

// File: tb/tb_uart_frame_monitor.sv
module tb_uart_frame_monitor;
  import uart_mon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1, tx_line = 1'b1;
  logic        rx_en = 1'b1, tx_en = 1'b1;
  logic [15:0] cfg_cpb = 16'(CPB);
  logic [3:0]  cfg_nbits = 4'd8;
  logic        cfg_msb = 1'b0;
  logic [2:0]  cfg_par = 3'd0;
  logic        ev_valid, ev_ready = 1'b1, ev_dir;
  logic [2:0]  ev_kind;
  logic [8:0]  ev_payload;

  int          n_checks = 0;
  int          n_bad = 0;
  logic [12:0] got[$];
  logic [12:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_monitor dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tx_line(tx_line),
    .rx_en(rx_en), .tx_en(tx_en), .cfg_clks_per_bit(cfg_cpb),
    .cfg_data_bits(cfg_nbits), .cfg_msb_first(cfg_msb), .cfg_parity(cfg_par),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_dir(ev_dir),
    .ev_kind(ev_kind), .ev_payload(ev_payload)
  );

  always @(negedge clk)
    if (rst_n && ev_valid && ev_ready) got.push_back({ev_dir, ev_kind, ev_payload});

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  task automatic expect2(input bit [1:0] m, input int kind, input int pay);
    if (m[0]) exp_q.push_back({1'b0, 3'(kind), 9'(pay)});
    if (m[1]) exp_q.push_back({1'b1, 3'(kind), 9'(pay)});
  endtask

  task automatic drive(input bit [1:0] m, input bit v);
    if (m[0]) rx_line = v;
    if (m[1]) tx_line = v;
  endtask

  task automatic hold(input bit [1:0] m, input bit v);
    drive(m, v);
    repeat (CPB) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(got.size() == exp_q.size(), {req, " event count"}, got.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got.size()) chk(got[i] == exp_q[i], req, int'(got[i]), int'(exp_q[i]));
    got.delete();
    exp_q.delete();
  endtask

  // drv: wires driven, em: directions expected to report
  task automatic send_frame(input bit [1:0] drv, input bit [1:0] em, input int data,
                            input int nb, input bit msb, input int par, input bit flip,
                            input bit badstart, input bit badstop, input string req);
    int  d;
    bit  pc, pa;
    d  = data & ((1 << nb) - 1);
    pc = (par == 1) ? ~($countones(d) % 2 == 1) :
         (par == 2) ? ($countones(d) % 2 == 1) :
         (par == 4);
    pa = flip ? ~pc : pc;
    cfg_nbits = 4'(nb); cfg_msb = msb; cfg_par = 3'(par);
    @(negedge clk);
    if (badstart) begin
      drive(drv, 1'b0);
      repeat (2) @(negedge clk);
      drive(drv, 1'b1);
      repeat (CPB-2) @(negedge clk);
      expect2(em, 5, 1);
    end else begin
      hold(drv, 1'b0);
      expect2(em, 0, 0);
    end
    for (int i = 0; i < nb; i++) hold(drv, msb ? d[nb-1-i] : d[i]);
    expect2(em, 1, d);
    if (par != 0) begin
      hold(drv, pa);
      if (flip) expect2(em, 3, {pc, pa});
      else      expect2(em, 2, pa);
    end
    hold(drv, !badstop);
    expect2(em, badstop ? 6 : 4, badstop ? 0 : 1);
    drive(drv, 1'b1);
    repeat (2*CPB) @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_checks++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ev_valid, "R1 in reset", ev_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ev_valid, "R1 after reset", ev_valid, 0);

    // Sweep: every width, parity mode and bit order on the receive wire.
    for (int nb = 5; nb <= 9; nb++)
      for (int par = 0; par <= 4; par++)
        for (int msb = 0; msb <= 1; msb++) begin
          int d1;
          string tag;
          d1  = (nb*53 + par*29 + msb*7 + 5);
          tag = $sformatf("%s %s nb=%0d par=%0d R2 R9",
                          msb ? "R5" : "R4",
                          par == 0 ? "R8" : (par <= 2 ? "R6" : "R7"), nb, par);
          send_frame(2'b01, 2'b01, d1, nb, msb[0], par, 1'b0, 1'b0, 1'b0, tag);
          send_frame(2'b01, 2'b01, ~d1, nb, msb[0], par, 1'b0, 1'b0, 1'b0, tag);
        end

    // Parity mismatches in every parity mode, on the transmit wire.
    for (int par = 1; par <= 4; par++)
      send_frame(2'b10, 2'b10, 8'hA7 + par, 8, 1'b0, par, 1'b1, 1'b0, 1'b0,
                 par <= 2 ? "R6 mismatch R10" : "R7 mismatch R10");

    // Start bit read high: decoding carries on.
    send_frame(2'b01, 2'b01, 8'h3C, 8, 1'b0, 2, 1'b0, 1'b1, 1'b0, "R3 bad start");
    send_frame(2'b10, 2'b10, 9'h1C5, 9, 1'b1, 1, 1'b0, 1'b1, 1'b0, "R3 bad start tx");

    // Stop bit low, with and without a parity slot.
    send_frame(2'b01, 2'b01, 8'h81, 8, 1'b0, 0, 1'b0, 1'b0, 1'b1, "R9 R8 bad stop at N+1");
    send_frame(2'b10, 2'b10, 7'h55, 7, 1'b1, 3, 1'b0, 1'b0, 1'b1, "R9 bad stop");
    send_frame(2'b01, 2'b01, 8'h42, 8, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R9 recovers after bad stop");

    // Centre timing of the start sample.
    fork
      send_frame(2'b01, 2'b01, 8'h96, 8, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R2 timed frame");
      begin
        int n = 0;
        @(negedge clk);
        do begin
          @(negedge clk);
          n++;
        end while (!ev_valid && n < 100);
        chk(n == CPB/2 + 3, "R2 start sample edge count", n, CPB/2 + 3);
      end
    join

    // Both wires at once: receive first, transmit held; short stall.
    @(posedge clk); #(CLK_PERIOD/4) ev_ready = 1'b0;
    fork
      send_frame(2'b11, 2'b11, 8'h5A, 8, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R10 R12 concurrent");
      begin
        logic [12:0] first;
        @(negedge clk);
        while (!ev_valid) @(negedge clk);
        first = {ev_dir, ev_kind, ev_payload};
        chk(first == 13'h0000, "R12 receive offered first", int'(first), 0);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(ev_valid && {ev_dir, ev_kind, ev_payload} == first, "R12 stable under stall",
              int'({ev_dir, ev_kind, ev_payload}), int'(first));
        end
        @(posedge clk); #(CLK_PERIOD/4) ev_ready = 1'b1;
      end
    join

    // Disabled transmit wire reports nothing; receive still works.
    tx_en = 1'b0;
    send_frame(2'b10, 2'b00, 8'hF0, 8, 1'b0, 2, 1'b0, 1'b0, 1'b0, "R11 disabled tx silent");
    send_frame(2'b11, 2'b01, 8'h0F, 8, 1'b0, 2, 1'b0, 1'b0, 1'b0, "R11 only rx reports");
    tx_en = 1'b1;
    rx_en = 1'b0;
    send_frame(2'b11, 2'b10, 6'h2D, 6, 1'b1, 4, 1'b0, 1'b0, 1'b0, "R11 only tx reports R10");
    rx_en = 1'b1;

    summary();
  end

endmodule